// File: doc/BRIEF.md
# Scheduled Time-Triggered Pulse Generator

This block fires a pulse when a running time reference reaches an absolute trigger time that a host has set. The time reference is a seconds count plus a count of reference-clock cycles within the current second. It advances in the reference clock domain. The host sits in a separate system clock domain. It presents a trigger time, made of seconds and cycles, together with a one-cycle strobe. It writes a new trigger only while the ready output is high.

The accepted trigger is held in the system domain. A toggle is sent across to the reference domain, and that domain copies the held value once the toggle has passed its synchronizer. The reference domain then compares the trigger against the running time every cycle. On an exact match of both fields it drives a pulse of fixed length. It then returns an acknowledge toggle, and that toggle raises ready again. The reference domain also drops a request without firing in two cases: the time reference stops being valid, or the trigger's cycle field can never occur. Either way it acknowledges the request, so the host is never left waiting.

Top module: `sched_pulse_gen`

## Requirements
- R1: After reset, ready_o is 1 and pulse_o is 0.
- R2: A trigger_valid_i strobe, taken while ready_o is 1 and time_valid_i is 1, is accepted. ready_o reads 0 in the next system clock cycle.
- R3: pulse_o rises one reference cycle after the cycle in which tm_sec_i and tm_cyc_i both equal the accepted trigger's seconds and cycles.
- R4: Each pulse stays high for exactly PULSE_LEN reference clock cycles.
- R5: After a pulse fires, ready_o returns to 1 within a few system clock cycles.
- R6: A strobe taken while ready_o is 0 is ignored. The pending trigger still fires at its own time, and no second pulse appears.
- R7: While time_valid_i is 0, pulse_o stays 0, ready_o reads 1, and strobes are discarded: no pulse follows them even after time becomes valid again.
- R8: If time_valid_i falls while a trigger is pending, that trigger is dropped. ready_o is 1 after time becomes valid again, and no pulse appears at the dropped time.
- R9: A trigger whose cycle field is REF_CLK_HZ or larger is dropped without a pulse, and ready_o returns to 1.
- R10: The seconds field takes part in the match. A trigger set in a later second fires only in that second, at the programmed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (host side) |
| ref_clk_i | input | 1 | Reference clock (time base side) |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| time_valid_i | input | 1 | Time reference valid, reference domain |
| tm_sec_i | input | 40 | Running seconds, reference domain |
| tm_cyc_i | input | 28 | Running cycle within the second, reference domain |
| trig_sec_i | input | 40 | Trigger seconds, system domain |
| trig_cyc_i | input | 28 | Trigger cycle, system domain |
| trig_valid_i | input | 1 | One-cycle trigger strobe, system domain |
| ready_o | output | 1 | High when a new trigger may be written, system domain |
| pulse_o | output | 1 | Output pulse, reference domain |

## Verification
The assertions check four things on every cycle:
- a strobe taken while ready is low never launches a request;
- an accepted strobe leaves the request pending in the next cycle;
- a new request never arrives while another is pending;
- an invalid time reference clears both the pending trigger and the pulse, and every rising pulse follows a match.

The bench scenarios show what no single-cycle property can: the exact reference cycle at which the pulse rises, the pulse width, the return of ready after the acknowledge crosses back, and the absence of a pulse when a request was ignored or dropped.

// File: rtl/sched_pulse_pkg.sv
package sched_pulse_pkg;
  localparam int unsigned SEC_W = 40;
  localparam int unsigned CYC_W = 28;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [CYC_W-1:0] cyc;
  } tstamp_t;
endpackage

// File: rtl/sched_pulse_sync.sv
module sched_pulse_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '0;
    else         s_q <= {s_q[STAGES-2:0], d_i};
  end

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/sched_pulse_host.sv
module sched_pulse_host
  import sched_pulse_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  tstamp_t trig_i,
  input  logic    trig_valid_i,
  input  logic    tv_sync_i,
  input  logic    ack_tog_i,
  output logic    req_tog_o,
  output tstamp_t hold_o,
  output logic    ready_o
);
  logic    ack_s;
  logic    req_q;
  tstamp_t hold_q;
  logic    busy;
  logic    accept;

  sched_pulse_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_tog_i),
    .q_o   (ack_s)
  );

  // request outstanding until ack toggle catches up
  assign busy    = req_q ^ ack_s;
  assign accept  = trig_valid_i && !busy && tv_sync_i;
  assign ready_o = !busy || !tv_sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else if (accept) begin
      req_q  <= ~req_q;
      hold_q <= trig_i;
    end
  end

  assign req_tog_o = req_q;
  assign hold_o    = hold_q;

  AST_STROBE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_valid_i && !ready_o) |=> $stable(req_q)); // R6

  AST_ACCEPT_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_valid_i && ready_o && tv_sync_i) |=> (req_q != ack_s)); // R2
endmodule

// File: rtl/sched_pulse_ref.sv
module sched_pulse_ref
  import sched_pulse_pkg::*;
#(
  parameter int unsigned REF_CLK_HZ  = 125000000,
  parameter int unsigned PULSE_LEN   = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic    ref_clk_i,
  input  logic    rst_ni,
  input  logic    time_valid_i,
  input  tstamp_t now_i,
  input  logic    req_tog_i,
  input  tstamp_t hold_i,
  output logic    ack_tog_o,
  output logic    pulse_o
);
  localparam int unsigned LEN_W = $clog2(PULSE_LEN + 1);
  localparam logic [CYC_W:0] CYC_LIM = (CYC_W + 1)'(REF_CLK_HZ);

  logic             req_s;
  logic             seen_q;
  logic             armed_q;
  logic             ack_q;
  tstamp_t          tgt_q;
  logic [LEN_W-1:0] cnt_q;
  logic             new_req;
  logic             in_range;
  logic             hit;

  sched_pulse_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_tog_i),
    .q_o   (req_s)
  );

  assign new_req  = req_s ^ seen_q;
  assign in_range = {1'b0, hold_i.cyc} < CYC_LIM;
  assign hit      = armed_q && (now_i == tgt_q);

  // request tracking: arm, fire or drop, ack on every exit
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      armed_q <= 1'b0;
      ack_q   <= 1'b0;
      tgt_q   <= '0;
    end else if (new_req) begin
      seen_q <= req_s;
      if (time_valid_i && in_range) begin
        armed_q <= 1'b1;
        tgt_q   <= hold_i;
      end else begin
        ack_q <= ~ack_q;
      end
    end else if (armed_q && (!time_valid_i || hit)) begin
      armed_q <= 1'b0;
      ack_q   <= ~ack_q;
    end
  end

  // pulse stretcher
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!time_valid_i)  cnt_q <= '0;
    else if (hit)            cnt_q <= LEN_W'(PULSE_LEN);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o   = (cnt_q != '0);
  assign ack_tog_o = ack_q;

  AST_NO_PULSE_INVALID: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !time_valid_i |=> !pulse_o); // R7

  AST_DROP_ON_INVALID: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !time_valid_i |=> !armed_q); // R8

  AST_MATCH_FIRES: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (hit && time_valid_i) |=> pulse_o); // R3

  AST_RISE_FROM_MATCH: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(hit)); // R3

  AST_SINGLE_PENDING: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    new_req |-> !armed_q); // R6
endmodule

// File: rtl/sched_pulse_gen.sv
module sched_pulse_gen
  import sched_pulse_pkg::*;
#(
  parameter int unsigned REF_CLK_HZ  = 125000000,
  parameter int unsigned PULSE_LEN   = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic             time_valid_i,
  input  logic [SEC_W-1:0] tm_sec_i,
  input  logic [CYC_W-1:0] tm_cyc_i,
  input  logic [SEC_W-1:0] trig_sec_i,
  input  logic [CYC_W-1:0] trig_cyc_i,
  input  logic             trig_valid_i,
  output logic             ready_o,
  output logic             pulse_o
);
  logic    tv_sys;
  logic    req_tog;
  logic    ack_tog;
  tstamp_t hold;
  tstamp_t trig;
  tstamp_t now;

  assign trig = '{sec: trig_sec_i, cyc: trig_cyc_i};
  assign now  = '{sec: tm_sec_i, cyc: tm_cyc_i};

  sched_pulse_sync #(.STAGES(SYNC_STAGES)) u_tv_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (time_valid_i),
    .q_o   (tv_sys)
  );

  sched_pulse_host #(.SYNC_STAGES(SYNC_STAGES)) u_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig),
    .trig_valid_i(trig_valid_i),
    .tv_sync_i   (tv_sys),
    .ack_tog_i   (ack_tog),
    .req_tog_o   (req_tog),
    .hold_o      (hold),
    .ready_o     (ready_o)
  );

  sched_pulse_ref #(
    .REF_CLK_HZ (REF_CLK_HZ),
    .PULSE_LEN  (PULSE_LEN),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ref (
    .ref_clk_i   (ref_clk_i),
    .rst_ni      (rst_ni),
    .time_valid_i(time_valid_i),
    .now_i       (now),
    .req_tog_i   (req_tog),
    .hold_i      (hold),
    .ack_tog_o   (ack_tog),
    .pulse_o     (pulse_o)
  );
endmodule

// File: tb/sched_pulse_gen_bench.sv
`timescale 1ns/1ps
module sched_pulse_gen_bench;
  localparam int RATE = 100;
  localparam int PLEN = 3;

  logic        clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tv = 1'b1;
  logic [39:0] tm_sec;
  logic [27:0] tm_cyc;
  logic [39:0] t_sec = '0;
  logic [27:0] t_cyc = '0;
  logic        t_valid = 1'b0;
  logic        ready;
  logic        pulse;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always #3.5 ref_clk = ~ref_clk;

  sched_pulse_gen #(.REF_CLK_HZ(RATE), .PULSE_LEN(PLEN)) u_sched_pulse_gen (
    .clk_i(clk), .ref_clk_i(ref_clk), .rst_ni(rst_n), .time_valid_i(tv),
    .tm_sec_i(tm_sec), .tm_cyc_i(tm_cyc),
    .trig_sec_i(t_sec), .trig_cyc_i(t_cyc), .trig_valid_i(t_valid),
    .ready_o(ready), .pulse_o(pulse));

  // time reference model
  always @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_sec <= 40'd5;
      tm_cyc <= '0;
    end else if (tm_cyc == 28'(RATE - 1)) begin
      tm_cyc <= '0;
      tm_sec <= tm_sec + 1'b1;
    end else begin
      tm_cyc <= tm_cyc + 1'b1;
    end
  end

  // pulse monitor
  int     rise_cnt = 0;
  int     run = 0;
  int     last_width = 0;
  longint rise_sec = 0, rise_cyc = 0, ls = 0, lc = 0;
  logic   prev = 1'b0;
  always @(negedge ref_clk) begin
    if (pulse && !prev) begin
      rise_cnt = rise_cnt + 1;
      rise_sec = ls;
      rise_cyc = lc;
      run = 1;
    end else if (pulse) begin
      run = run + 1;
    end else if (prev) begin
      last_width = run;
    end
    prev = pulse;
    ls = longint'(tm_sec);
    lc = longint'(tm_cyc);
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic future(input int d, output longint s, output longint c);
    s = longint'(tm_sec);
    c = longint'(tm_cyc) + d;
    while (c >= RATE) begin
      c -= RATE;
      s++;
    end
  endtask

  task automatic strobe(input longint s, input longint c);
    @(negedge clk);
    t_sec = 40'(s);
    t_cyc = 28'(c);
    t_valid = 1'b1;
    @(negedge clk);
    t_valid = 1'b0;
  endtask

  task automatic ref_wait(input int n);
    repeat (n) @(posedge ref_clk);
    #1;
  endtask

  task automatic wait_rise(input int base, input int limit);
    for (int i = 0; i < limit && rise_cnt == base; i++) ref_wait(1);
  endtask

  task automatic wait_ready(input int limit, output bit seen);
    seen = 0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge clk);
      seen = ready;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(ready === 1'b1, "R1 ready", longint'(ready), 1);
    check(pulse === 1'b0, "R1 pulse", longint'(pulse), 0);
  endtask

  task automatic t_basic;
    longint s, c;
    int base;
    bit seen;
    base = rise_cnt;
    future(40, s, c);
    strobe(s, c);
    check(ready === 1'b0, "R2 ready low", longint'(ready), 0);
    wait_rise(base, 400);
    check(rise_cnt == base + 1, "R3 fired", rise_cnt, base + 1);
    check(rise_sec == s, "R3 sec", rise_sec, s);
    check(rise_cyc == c, "R3 cyc", rise_cyc, c);
    ref_wait(PLEN + 3);
    check(last_width == PLEN, "R4 width", last_width, PLEN);
    wait_ready(20, seen);
    check(seen, "R5 ready back", longint'(seen), 1);
  endtask

  task automatic t_busy;
    longint sa, ca, sb, cb;
    int base;
    bit seen;
    base = rise_cnt;
    future(70, sa, ca);
    strobe(sa, ca);
    @(negedge clk);
    check(ready === 1'b0, "R6 busy", longint'(ready), 0);
    future(20, sb, cb);
    strobe(sb, cb);
    wait_rise(base, 400);
    check(rise_sec == sa && rise_cyc == ca, "R6 first kept", rise_cyc, ca);
    ref_wait(60);
    check(rise_cnt == base + 1, "R6 single pulse", rise_cnt, base + 1);
    wait_ready(20, seen);
    check(seen, "R6 ready back", longint'(seen), 1);
  endtask

  task automatic t_second;
    longint s, c;
    int base;
    bit seen;
    base = rise_cnt;
    s = longint'(tm_sec) + 1;
    c = 2;
    if (longint'(tm_cyc) > RATE - 30) s++;
    strobe(s, c);
    wait_rise(base, 4 * RATE);
    check(rise_sec == s, "R10 sec", rise_sec, s);
    check(rise_cyc == c, "R10 cyc", rise_cyc, c);
    wait_ready(20, seen);
  endtask

  task automatic t_range;
    int base;
    bit seen;
    base = rise_cnt;
    strobe(longint'(tm_sec) + 1, RATE);
    check(ready === 1'b0, "R9 accepted", longint'(ready), 0);
    wait_ready(20, seen);
    check(seen, "R9 dropped ready", longint'(seen), 1);
    ref_wait(3 * RATE);
    check(rise_cnt == base, "R9 no pulse", rise_cnt, base);
  endtask

  task automatic t_invalid;
    longint s, c;
    int base;
    bit seen;
    base = rise_cnt;
    @(negedge ref_clk);
    tv = 1'b0;
    repeat (5) @(negedge clk);
    check(ready === 1'b1, "R7 ready high", longint'(ready), 1);
    future(30, s, c);
    strobe(s, c);
    check(ready === 1'b1, "R7 strobe discarded", longint'(ready), 1);
    ref_wait(60);
    check(rise_cnt == base, "R7 no pulse invalid", rise_cnt, base);
    @(negedge ref_clk);
    tv = 1'b1;
    wait_ready(10, seen);
    ref_wait(2 * RATE);
    check(rise_cnt == base, "R7 no pulse later", rise_cnt, base);
  endtask

  task automatic t_drop;
    longint s, c;
    int base;
    bit seen;
    base = rise_cnt;
    future(90, s, c);
    strobe(s, c);
    check(ready === 1'b0, "R8 armed", longint'(ready), 0);
    ref_wait(10);
    @(negedge ref_clk);
    tv = 1'b0;
    ref_wait(4);
    @(negedge ref_clk);
    tv = 1'b1;
    repeat (10) @(negedge clk);
    check(ready === 1'b1, "R8 ready after drop", longint'(ready), 1);
    ref_wait(150);
    check(rise_cnt == base, "R8 no pulse", rise_cnt, base);
  endtask

  initial begin
    #105;
    rst_n = 1'b1;
    t_reset();
    ref_wait(5);
    t_basic();
    t_busy();
    t_second();
    t_range();
    t_invalid();
    t_drop();
    t_basic();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule